// File: doc/BRIEF.md
# Sleep and Interrupt Wake-up Controller

This block sequences power-down and wake-up for a small processor core whose instruction cycle is four clock phases long. The core presents a decoded sleep request and a clear-watchdog request during an instruction cycle. The controller acts on them only in the last phase of that cycle. A sleep request is taken in only when no enabled interrupt is pending at that moment. Otherwise it finishes as a no-op and leaves all status untouched.

Once the sleep is taken in, the watchdog is cleared, the power-down flag drops and the timeout flag rises. The core clock gate then closes. Any pending enabled interrupt reopens it, whatever the global interrupt enable says. In crystal oscillator modes a start-up timer first counts 1024 oscillator periods. After reopening, the core executes the instruction that follows the sleep. It then either continues in line or takes a dummy cycle and jumps to the interrupt vector, depending on the global enable.

Top module: `sleep_wake_ctl`

## Requirements
- R1: While reset is low, coreClkEn is 1, qPhase is 0, dogClr is 0, pwrDownFlag is 1 and timeoutFlag is 1.
- R2: While the core clock is open, qPhase steps 0,1,2,3,0 once per clock; sleepReq and clrDogReq count only on the clock edge where qPhase is 3.
- R3: If intPending is 1 at the edge where a sleep request counts, the request is a no-op: the clock stays open, no dogClr pulse occurs, and pwrDownFlag and timeoutFlag keep their values.
- R4: An accepted sleep request gives, one clock after its counting edge, a dogClr pulse of exactly one cycle with pwrDownFlag 0 and timeoutFlag 1; coreClkEn drops one clock later.
- R5: With the clock gate closed and no interrupt pending, it stays closed; an interrupt that appears in the cycle just after the accepted request still wakes the block one clock after the gate closes.
- R6: Wake-up happens whatever the value of intGlobalEn.
- R7: With xtalMode 0, coreClkEn is 1 on the clock after the first edge that sees intPending while asleep.
- R8: With xtalMode 1, after the wake edge coreClkEn stays 0 for 1025 clocks while the start-up timer counts 1024 periods; suTimerRun is 1 exactly during that wait.
- R9: With intGlobalEn 1 at the end of the first reopened instruction cycle, a second (dummy) cycle follows and vectorFetch pulses in its phase 3, the 8th clock after reopening; continueInline does not pulse.
- R10: With intGlobalEn 0 at that point, continueInline pulses in phase 3 of the first reopened cycle, the 4th clock after reopening; vectorFetch does not pulse.
- R11: A counted clear-watchdog request gives a one-cycle dogClr pulse one clock later and sets both pwrDownFlag and timeoutFlag to 1.
- R12: A high dogTimeout clears timeoutFlag on the next clock, unless an accepted sleep or clear request sets it on that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Power-on reset, active low |
| sleepReq | input | 1 | Decoded sleep instruction in execute |
| clrDogReq | input | 1 | Decoded clear-watchdog instruction in execute |
| intPending | input | 1 | Some interrupt source has flag and enable both set |
| intGlobalEn | input | 1 | Global interrupt enable |
| xtalMode | input | 1 | 1 for crystal-type oscillator modes needing start-up delay |
| dogTimeout | input | 1 | Watchdog counter expiry |
| coreClkEn | output | 1 | Core clock gate enable |
| qPhase | output | 2 | Current phase within the instruction cycle |
| suTimerRun | output | 1 | Start-up timer counting |
| dogClr | output | 1 | Watchdog and postscaler clear pulse |
| pwrDownFlag | output | 1 | Power-down status flag |
| timeoutFlag | output | 1 | Timeout status flag |
| vectorFetch | output | 1 | Core fetches from the interrupt vector |
| continueInline | output | 1 | Core continues in line after wake-up |

## Verification
The assertions assume that sleepReq and clrDogReq only matter in phase 3, so consecutive dogClr pulses are at least one instruction cycle apart. They also assume that intPending is the only route out of the asleep state. The stimulus raises each request for a single clock aligned to phase 3 while the block runs. It raises intPending only for the no-op case or to wake the block, and drops it once the gate has reopened. Expected pulse times for dogClr, vectorFetch and continueInline are queued before each sleep or wake and matched to the cycle.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTRY,
    ST_ASLEEP,
    ST_WARMUP,
    ST_RESUME,
    ST_VECTOR
  } slpState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic gateOpen;
    logic sleepExec;
    logic clrReq;
    logic timerEnable;
  } slpStrobe_t;

endpackage

// File: rtl/sleep_wake_dp.sv
module sleep_wake_dp
  import sleep_wake_pkg::*;
#(
  parameter int PHASES     = 4,
  parameter int OST_CYCLES = 1024,
  localparam int PW = $clog2(PHASES),
  localparam int CW = $clog2(OST_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  slpStrobe_t    strb,
  input  logic          dogTimeout,
  output logic [PW-1:0] phase,
  output logic          qLast,
  output logic          timerDone,
  output logic          dogClr,
  output logic          pwrDownFlag,
  output logic          timeoutFlag
);

  logic [CW-1:0] suCount;

  assign qLast     = (phase == PW'(PHASES - 1));
  assign timerDone = (suCount == CW'(OST_CYCLES));

  // phase counter runs only while the core clock is open
  always_ff @(posedge clk) begin
    if (!rstN || !strb.gateOpen) begin
      phase <= '0;
    end else if (qLast) begin
      phase <= '0;
    end else begin
      phase <= phase + PW'(1);
    end
  end

  // start-up timer, held clear outside the warm-up wait
  always_ff @(posedge clk) begin
    if (!rstN || !strb.timerEnable) begin
      suCount <= '0;
    end else if (!timerDone) begin
      suCount <= suCount + CW'(1);
    end
  end

  // status flags and watchdog clear pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrDownFlag <= 1'b1;
      timeoutFlag <= 1'b1;
      dogClr      <= 1'b0;
    end else begin
      dogClr <= strb.sleepExec | strb.clrReq;
      if (strb.sleepExec) begin
        pwrDownFlag <= 1'b0;
        timeoutFlag <= 1'b1;
      end else if (strb.clrReq) begin
        pwrDownFlag <= 1'b1;
        timeoutFlag <= 1'b1;
      end else if (dogTimeout) begin
        timeoutFlag <= 1'b0;
      end
    end
  end

  // R4
  dogclr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    dogClr |=> !dogClr);

  // R4
  pd_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrDownFlag) |-> (dogClr && timeoutFlag));

  // R8
  timer_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    suCount <= CW'(OST_CYCLES));

  // R2
  phase_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.gateOpen |=> (phase == '0));

endmodule

// File: rtl/sleep_wake_fsm.sv
module sleep_wake_fsm
  import sleep_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       clrDogReq,
  input  logic       intPending,
  input  logic       intGlobalEn,
  input  logic       xtalMode,
  input  logic       qLast,
  input  logic       timerDone,
  output slpStrobe_t strb,
  output logic       vectorFetch,
  output logic       continueInline
);

  slpState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:    if (qLast && sleepReq && !intPending) stateNext = ST_ENTRY;
      ST_ENTRY:  stateNext = ST_ASLEEP;
      ST_ASLEEP: if (intPending) stateNext = xtalMode ? ST_WARMUP : ST_RESUME;
      ST_WARMUP: if (timerDone) stateNext = ST_RESUME;
      ST_RESUME: if (qLast) stateNext = intGlobalEn ? ST_VECTOR : ST_RUN;
      ST_VECTOR: if (qLast) stateNext = ST_RUN;
      default:   stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    strb.gateOpen    = !(state == ST_ASLEEP || state == ST_WARMUP);
    strb.sleepExec   = (state == ST_RUN) && qLast && sleepReq && !intPending;
    strb.clrReq      = (state == ST_RUN) && qLast && clrDogReq && !strb.sleepExec;
    strb.timerEnable = (state == ST_WARMUP);
  end

  assign vectorFetch    = (state == ST_VECTOR) && qLast;
  assign continueInline = (state == ST_RESUME) && qLast && !intGlobalEn;

  // R5
  asleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ASLEEP && !intPending) |=> (state == ST_ASLEEP));

  // R8
  warmup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WARMUP && !timerDone) |=> (state == ST_WARMUP));

  // R7
  reopen_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.gateOpen) |-> (state == ST_RESUME));

  // R9
  vector_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VECTOR) |-> ($past(state) == ST_RESUME || $past(state) == ST_VECTOR));

endmodule

// File: rtl/sleep_wake_ctl.sv
module sleep_wake_ctl
  import sleep_wake_pkg::*;
#(
  parameter int PHASES     = 4,
  parameter int OST_CYCLES = 1024,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sleepReq,
  input  logic          clrDogReq,
  input  logic          intPending,
  input  logic          intGlobalEn,
  input  logic          xtalMode,
  input  logic          dogTimeout,
  output logic          coreClkEn,
  output logic [PW-1:0] qPhase,
  output logic          suTimerRun,
  output logic          dogClr,
  output logic          pwrDownFlag,
  output logic          timeoutFlag,
  output logic          vectorFetch,
  output logic          continueInline
);

  slpStrobe_t strb;
  logic       qLast;
  logic       timerDone;

  sleep_wake_fsm u_fsm (
    .clk            (clk),
    .rstN           (rstN),
    .sleepReq       (sleepReq),
    .clrDogReq      (clrDogReq),
    .intPending     (intPending),
    .intGlobalEn    (intGlobalEn),
    .xtalMode       (xtalMode),
    .qLast          (qLast),
    .timerDone      (timerDone),
    .strb           (strb),
    .vectorFetch    (vectorFetch),
    .continueInline (continueInline)
  );

  sleep_wake_dp #(
    .PHASES     (PHASES),
    .OST_CYCLES (OST_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dogTimeout  (dogTimeout),
    .phase       (qPhase),
    .qLast       (qLast),
    .timerDone   (timerDone),
    .dogClr      (dogClr),
    .pwrDownFlag (pwrDownFlag),
    .timeoutFlag (timeoutFlag)
  );

  assign coreClkEn  = strb.gateOpen;
  assign suTimerRun = strb.timerEnable;

endmodule

// File: tb/sim_sleep_wake_ctl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0, clrDogReq = 1'b0, intPending = 1'b0;
  logic intGlobalEn = 1'b0, xtalMode = 1'b0, dogTimeout = 1'b0;
  logic coreClkEn, suTimerRun, dogClr, pwrDownFlag, timeoutFlag;
  logic vectorFetch, continueInline;
  logic [1:0] qPhase;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int kind; int at; string req; } ev_t;
  ev_t expQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sleep_wake_ctl u0 (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .clrDogReq(clrDogReq),
    .intPending(intPending), .intGlobalEn(intGlobalEn), .xtalMode(xtalMode),
    .dogTimeout(dogTimeout), .coreClkEn(coreClkEn), .qPhase(qPhase),
    .suTimerRun(suTimerRun), .dogClr(dogClr), .pwrDownFlag(pwrDownFlag),
    .timeoutFlag(timeoutFlag), .vectorFetch(vectorFetch), .continueInline(continueInline)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kinds: 0 dogClr, 1 vectorFetch, 2 continueInline
  task automatic expectEv(int kind, int at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic popEv(int kind);
    ev_t e;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL R3 R9 R10 unexpected event actual kind %0d cycle %0d expected none", kind, cyc);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        errors++;
        $display("FAIL %s actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: pops expected pulses as the design produces them
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (dogClr)         popEv(0);
      if (vectorFetch)    popEv(1);
      if (continueInline) popEv(2);
    end
  end

  task automatic waitQ4();
    @(negedge clk);
    while (qPhase != 2'd3) @(negedge clk);
  endtask

  // driver: issue a sleep request in phase 3, return at the following negedge
  task automatic doSleep(bit accepted, string req, output int c);
    waitQ4();
    sleepReq = 1'b1;
    c = cyc;
    if (accepted) expectEv(0, c + 1, req);
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  task automatic wakeFast(bit gieVal, string req);
    int w;
    intGlobalEn = gieVal;
    xtalMode = 1'b0;
    @(negedge clk);
    intPending = 1'b1;
    w = cyc;
    if (gieVal) expectEv(1, w + 8, req);
    else        expectEv(2, w + 4, req);
    @(negedge clk);
    intPending = 1'b0;
    chk("R7 clock reopens next clock", coreClkEn, 1);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int c, w, n, p0;
    repeat (3) @(negedge clk);
    chk("R1 coreClkEn", coreClkEn, 1);
    chk("R1 qPhase", qPhase, 0);
    chk("R1 dogClr", dogClr, 0);
    chk("R1 pwrDownFlag", pwrDownFlag, 1);
    chk("R1 timeoutFlag", timeoutFlag, 1);
    rstN = 1'b1;

    // R2 phase sequence
    for (int i = 0; i < 5; i++) begin
      p0 = qPhase;
      @(negedge clk);
      chk("R2 phase step", qPhase, (p0 + 1) % 4);
    end

    // R12 timeout clears flag
    dogTimeout = 1'b1;
    @(negedge clk);
    dogTimeout = 1'b0;
    chk("R12 timeoutFlag cleared", timeoutFlag, 0);

    // R11 clear request
    waitQ4();
    clrDogReq = 1'b1;
    expectEv(0, cyc + 1, "R11 dogClr pulse");
    @(negedge clk);
    clrDogReq = 1'b0;
    chk("R11 pwrDownFlag", pwrDownFlag, 1);
    chk("R11 timeoutFlag", timeoutFlag, 1);

    dogTimeout = 1'b1;
    @(negedge clk);
    dogTimeout = 1'b0;
    chk("R12 timeoutFlag cleared again", timeoutFlag, 0);

    // R3 no-op sleep with interrupt already pending
    intPending = 1'b1;
    doSleep(1'b0, "R3", c);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (!coreClkEn) n++;
      @(negedge clk);
    end
    intPending = 1'b0;
    chk("R3 clock stays open", n, 0);
    chk("R3 pwrDownFlag kept", pwrDownFlag, 1);
    chk("R3 timeoutFlag kept", timeoutFlag, 0);

    // R4 R5 R6 R10 accepted sleep, non-crystal, global enable off
    doSleep(1'b1, "R4 dogClr pulse", c);
    chk("R4 pwrDownFlag", pwrDownFlag, 0);
    chk("R4 timeoutFlag", timeoutFlag, 1);
    chk("R4 clock open in entry", coreClkEn, 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (coreClkEn) n++;
    end
    chk("R5 clock stays closed", n, 0);
    wakeFast(1'b0, "R10 continueInline (R6 wake with enable off)");

    // R9 vectoring with global enable on
    doSleep(1'b1, "R4 dogClr pulse", c);
    repeat (4) @(negedge clk);
    wakeFast(1'b1, "R9 vectorFetch");

    // R8 crystal mode start-up wait
    intGlobalEn = 1'b0;
    doSleep(1'b1, "R4 dogClr pulse", c);
    repeat (4) @(negedge clk);
    xtalMode = 1'b1;
    intPending = 1'b1;
    w = cyc;
    expectEv(2, w + 1029, "R8 R10 continueInline after start-up");
    @(negedge clk);
    intPending = 1'b0;
    chk("R8 suTimerRun during wait", suTimerRun, 1);
    n = 0;
    while (!coreClkEn && n < 3000) begin
      n++;
      @(negedge clk);
    end
    chk("R8 closed clocks after wake", n, 1025);
    chk("R8 suTimerRun after wait", suTimerRun, 0);
    xtalMode = 1'b0;
    repeat (10) @(negedge clk);

    // R5 interrupt during the entry cycle
    doSleep(1'b1, "R4 dogClr pulse", c);
    intPending = 1'b1;
    expectEv(2, c + 6, "R5 R10 continueInline after late interrupt");
    @(negedge clk);
    chk("R5 clock closes despite interrupt", coreClkEn, 0);
    @(negedge clk);
    chk("R5 clock reopens", coreClkEn, 1);
    intPending = 1'b0;
    repeat (20) @(negedge clk);

    chk("R3 R9 R10 all expected pulses seen", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule